// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This unit decides control transfers for an in-order pipeline that has one architectural delay slot. Each time an instruction retires, the unit receives the instruction's transfer kind, its two source operands and its target address. It then computes the next program counter. A taken transfer does not redirect at once. The unit stores the target and uses it when the following instruction, the delay slot, retires.

The supported transfers are:
- two signed sign-test branches: strictly positive, and zero-or-negative;
- "likely" versions of both sign tests, which skip the delay slot when the branch is not taken;
- a branch taken when any byte lane of its two operands matches;
- an absolute jump;
- a jump-and-link, which writes the return address to a fixed link register.

A transfer found inside a delay slot is dropped and flagged. The transfer already pending keeps priority.

Top module: `dbr_unit`

## Requirements
- R1: After reset the PC is zero, no redirect is pending, and redirect, annul, link_we and nest_err are all low.
- R2: Kind codes are 0 none, 1 positive, 2 not-positive, 3 positive-likely, 4 not-positive-likely, 5 lane match, 6 jump, 7 jump-and-link. Kinds 1 and 3 are taken when opa, read as a signed 32-bit value, is greater than zero.
- R3: Kinds 2 and 4 are taken when signed opa is zero or negative.
- R4: A taken transfer advances the PC by 4. The next step is the delay slot: during that step redirect is high and the PC loads the stored target.
- R5: A not-taken likely branch (kind 3 or 4) raises annul during its step and advances the PC by 8, so the delay slot is skipped. A not-taken plain branch advances the PC by 4 with annul low.
- R6: Kind 5 is taken when at least one of the four 8-bit lanes of opa equals the same lane of opb.
- R7: Kinds 6 and 7 are always taken. During its step, kind 7 raises link_we with link_idx equal to 31 and link_data equal to PC+8.
- R8: A non-zero kind issued in a delay slot raises nest_err, writes no link, does not annul, and leaves the earlier redirect to the stored target unchanged. The following step is an ordinary one.
- R9: While step is low the PC and the pending state hold, and redirect, annul, link_we and nest_err stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction retires this cycle |
| kind | input | 3 | Transfer kind of the retiring instruction |
| opa | input | 32 | First source operand |
| opb | input | 32 | Second source operand (lane match only) |
| target | input | 32 | Transfer target address |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | PC loaded at the next step |
| redirect | output | 1 | Delay slot retiring; PC loads stored target |
| annul | output | 1 | Delay slot skipped by a not-taken likely branch |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address written |
| nest_err | output | 1 | Transfer seen in a delay slot was dropped |

## Verification
Each sign-test kind, plain and likely, is swept over zero, one, minus one, the largest positive value, the most negative value and small values. These separate the strict test from the inclusive test and catch unsigned compares at the sign boundary. The lane branch is tried with exactly one lane equal (each of the four in turn), no lane equal, and all lanes equal, which exposes a stuck or swapped lane comparator. Jumps and nested transfers in a delay slot, with and without idle cycles in between, check link data and the priority of the first pending redirect.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [2:0] {
    XK_NONE  = 3'd0,
    XK_GTZ   = 3'd1,
    XK_LEZ   = 3'd2,
    XK_GTZ_L = 3'd3,
    XK_LEZ_L = 3'd4,
    XK_LANE  = 3'd5,
    XK_JMP   = 3'd6,
    XK_JAL   = 3'd7
  } xfer_kind_e;

  function automatic logic kind_likely(xfer_kind_e k);
    return (k == XK_GTZ_L) || (k == XK_LEZ_L);
  endfunction
endpackage

// File: rtl/dbr_lane_cmp.sv
module dbr_lane_cmp #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            any_eq
);
  localparam int LANES = XLEN / LANE_W;
  logic [LANES-1:0] lane_eq;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_eq[i] = (a[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]);
  end

  assign any_eq = |lane_eq;
endmodule

// File: rtl/dbr_cond.sv
module dbr_cond
  import dbr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  xfer_kind_e      kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            taken
);
  function automatic logic sign_pos(logic [XLEN-1:0] v);
    return !v[XLEN-1] && (v != '0);
  endfunction

  logic lane_hit;

  dbr_lane_cmp #(.XLEN(XLEN), .LANE_W(LANE_W)) u_lane (
    .a(opa), .b(opb), .any_eq(lane_hit)
  );

  always_comb begin
    unique case (kind)
      XK_GTZ, XK_GTZ_L: taken = sign_pos(opa);
      XK_LEZ, XK_LEZ_L: taken = !sign_pos(opa);
      XK_LANE:          taken = lane_hit;
      XK_JMP, XK_JAL:   taken = 1'b1;
      default:          taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            arm,
  input  logic            skip_slot,
  input  logic [XLEN-1:0] tgt_in,
  output logic [XLEN-1:0] pc_q,
  output logic            pend_q,
  output logic [XLEN-1:0] tgt_q,
  output logic [XLEN-1:0] pc_nxt
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  function automatic logic [XLEN-1:0] seq_pc(logic [XLEN-1:0] p, logic skip);
    return skip ? p + 2 * INSN_BYTES : p + INSN_BYTES;
  endfunction

  always_comb begin
    if (pend_q) pc_nxt = tgt_q;
    else        pc_nxt = seq_pc(pc_q, skip_slot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (step) begin
      pc_q <= pc_nxt;
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (arm) begin
        pend_q <= 1'b1;
        tgt_q  <= tgt_in;
      end
    end
  end
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit
  import dbr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LANE_W   = 8,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        kind,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   next_pc,
  output logic              redirect,
  output logic              annul,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_data,
  output logic              nest_err
);
  localparam logic [XLEN-1:0] RET_OFS = XLEN'(8);

  xfer_kind_e       kind_e;
  logic             taken;
  logic             pend_q;
  logic [XLEN-1:0]  tgt_q;
  logic [XLEN-1:0]  pc_q;
  logic             is_xfer;
  logic             fresh;
  logic             arm;
  logic             skip_slot;

  assign kind_e  = xfer_kind_e'(kind);
  assign is_xfer = (kind_e != XK_NONE);

  dbr_cond #(.XLEN(XLEN), .LANE_W(LANE_W)) u_cond (
    .kind(kind_e), .opa(opa), .opb(opb), .taken(taken)
  );

  assign fresh     = step && !pend_q;
  assign arm       = fresh && taken;
  assign skip_slot = !pend_q && kind_likely(kind_e) && !taken;

  dbr_seq #(.XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .arm(arm),
    .skip_slot(skip_slot), .tgt_in(target),
    .pc_q(pc_q), .pend_q(pend_q), .tgt_q(tgt_q), .pc_nxt(next_pc)
  );

  assign pc        = pc_q;
  assign redirect  = step && pend_q;
  assign annul     = step && skip_slot;
  assign nest_err  = step && pend_q && is_xfer;
  assign link_we   = fresh && (kind_e == XK_JAL);
  assign link_idx  = RIDX_W'(LINK_REG);
  assign link_data = pc_q + RET_OFS;
endmodule

// File: rtl/dbr_unit_chk.sv
module dbr_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic [XLEN-1:0] pc_q,
  input logic            pend_q,
  input logic [XLEN-1:0] tgt_q,
  input logic            redirect,
  input logic            annul,
  input logic            link_we,
  input logic            nest_err
);
  AST_REDIRECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (pc_q == $past(tgt_q)) && !pend_q); // R4
  AST_ANNUL_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    annul |=> (pc_q == $past(pc_q) + XLEN'(8)) && !pend_q); // R5
  AST_LINK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |=> pend_q); // R7
  AST_NEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nest_err |-> redirect && !link_we && !annul); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q) && $stable(pend_q)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !redirect && !annul && !link_we && !nest_err); // R9
endmodule

bind dbr_unit dbr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .pc_q(pc_q), .pend_q(pend_q),
  .tgt_q(tgt_q), .redirect(redirect), .annul(annul), .link_we(link_we),
  .nest_err(nest_err)
);

// File: tb/dbr_unit_test.sv
module dbr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [31:0] opa = '0, opb = '0, target = '0;
  logic [31:0] pc, next_pc, link_data;
  logic        redirect, annul, link_we, nest_err;
  logic [4:0]  link_idx;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbr_unit uut (
    .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .opa(opa), .opb(opb),
    .target(target), .pc(pc), .next_pc(next_pc), .redirect(redirect),
    .annul(annul), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data), .nest_err(nest_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_taken(input int k, input logic [31:0] a, input logic [31:0] b);
    logic hit;
    hit = 1'b0;
    case (k)
      1, 3: return $signed(a) > 0;
      2, 4: return $signed(a) <= 0;
      5: begin
        for (int i = 0; i < 4; i++)
          if (((a >> (8*i)) & 32'hFF) == ((b >> (8*i)) & 32'hFF)) hit = 1'b1;
        return hit;
      end
      6, 7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Drive one retiring instruction; sample strobes mid-cycle, PC after the edge.
  task automatic issue(input int k, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] t, input logic s,
                       output logic o_red, output logic o_ann, output logic o_lwe,
                       output logic o_err, output logic [31:0] o_ld);
    @(negedge clk);
    step = s; kind = 3'(k); opa = a; opb = b; target = t;
    #1;
    o_red = redirect; o_ann = annul; o_lwe = link_we; o_err = nest_err; o_ld = link_data;
    @(posedge clk);
    #1;
    step = 1'b0;
  endtask

  // Full transfer: the issuing step, then a plain delay slot when taken.
  task automatic run_xfer(input string req, input int k, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] t);
    logic r, an, lw, er;
    logic [31:0] ld;
    logic tk, lk;
    tk = model_taken(k, a, b);
    lk = (k == 3 || k == 4);
    issue(k, a, b, t, 1'b1, r, an, lw, er, ld);
    chk({req, " annul"}, 32'(an), 32'(lk && !tk));
    chk({req, " link_we"}, 32'(lw), 32'(k == 7));
    if (k == 7) chk("R7 link_data", ld, exp_pc + 32'd8);
    if (tk) begin
      exp_pc = exp_pc + 32'd4;
      chk({req, " pc after issue"}, pc, exp_pc);
      issue(0, 32'd0, 32'd0, 32'd0, 1'b1, r, an, lw, er, ld);
      chk("R4 redirect in slot", 32'(r), 32'd1);
      exp_pc = t;
      chk({req, " pc at target"}, pc, exp_pc);
    end else begin
      exp_pc = exp_pc + (lk ? 32'd8 : 32'd4);
      chk({req, " pc not taken"}, pc, exp_pc);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic r, an, lw, er;
    logic [31:0] ld;
    logic [31:0] vals [7];
    logic [31:0] la;
    vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
             32'd5, 32'hFFFF_FFFE};

    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc", pc, 32'd0);
    chk("R1 redirect", 32'(redirect), 32'd0);
    chk("R1 annul", 32'(annul), 32'd0);
    chk("R1 link_we", 32'(link_we), 32'd0);
    chk("R1 nest_err", 32'(nest_err), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pc = 32'd0;

    issue(0, 0, 0, 0, 1'b1, r, an, lw, er, ld);
    exp_pc = 32'd4;
    chk("R4 plain step", pc, exp_pc);

    // R9: held step ignores a jump
    issue(7, 0, 0, 32'h4000, 1'b0, r, an, lw, er, ld);
    chk("R9 pc hold", pc, exp_pc);
    chk("R9 link_we", 32'(lw), 32'd0);
    chk("R9 annul", 32'(an), 32'd0);

    for (int k = 1; k <= 4; k++)
      for (int v = 0; v < 7; v++)
        run_xfer((k == 1 || k == 3) ? "R2" : "R3", k, vals[v], 32'd0,
                 32'h1000 + 32'(k * 256 + v * 16));
    // R5 explicit likely cases
    run_xfer("R5 gtz likely not taken", 3, 32'd0, 32'd0, 32'h2000);
    run_xfer("R5 lez likely not taken", 4, 32'd9, 32'd0, 32'h2100);

    la = 32'h1122_3344;
    for (int i = 0; i < 4; i++)
      run_xfer("R6 one lane", 5, la, la ^ ~(32'hFF << (8*i)), 32'h3000 + 32'(i * 64));
    run_xfer("R6 no lane", 5, la, ~la, 32'h3400);
    run_xfer("R6 all lanes", 5, la, la, 32'h3500);

    run_xfer("R7 jump", 6, 32'd0, 32'd0, 32'h5000);
    issue(7, 0, 0, 32'h6000, 1'b1, r, an, lw, er, ld);
    chk("R7 link_we", 32'(lw), 32'd1);
    chk("R7 link_idx", 32'(link_idx), 32'd31);
    chk("R7 link_data", ld, exp_pc + 32'd8);
    exp_pc = exp_pc + 32'd4;
    issue(0, 0, 0, 0, 1'b1, r, an, lw, er, ld);
    exp_pc = 32'h6000;
    chk("R7 pc at target", pc, exp_pc);

    // R8: jump-and-link in the slot of a jump, with an idle cycle between
    issue(6, 0, 0, 32'h7000, 1'b1, r, an, lw, er, ld);
    exp_pc = exp_pc + 32'd4;
    issue(0, 0, 0, 0, 1'b0, r, an, lw, er, ld);
    chk("R9 pending hold pc", pc, exp_pc);
    issue(7, 0, 0, 32'h8000, 1'b1, r, an, lw, er, ld);
    chk("R8 nest_err", 32'(er), 32'd1);
    chk("R8 no link", 32'(lw), 32'd0);
    chk("R8 redirect", 32'(r), 32'd1);
    exp_pc = 32'h7000;
    chk("R8 first target wins", pc, exp_pc);
    issue(0, 0, 0, 0, 1'b1, r, an, lw, er, ld);
    chk("R8 no later redirect", 32'(r), 32'd0);
    exp_pc = exp_pc + 32'd4;
    chk("R8 sequential after", pc, exp_pc);

    // R8: not-taken likely in a slot does not annul
    issue(6, 0, 0, 32'h9000, 1'b1, r, an, lw, er, ld);
    issue(3, 32'd0, 0, 32'hA000, 1'b1, r, an, lw, er, ld);
    chk("R8 slot annul", 32'(an), 32'd0);
    chk("R8 slot nest_err", 32'(er), 32'd1);
    chk("R8 slot target", pc, 32'h9000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule